// File: doc/BRIEF.md
# Single-Wire Debug Line Master

This block is the host end of a single-wire background debug link. The wire is shared by both ends and runs through an external level-shifting transceiver whose direction the block controls. A local client hands over one byte at a time, marked as either a write or a read. For a write, the block sends the eight bits as active-low pulses, most significant bit first. The length of each pulse tells the target whether the bit is a one or a zero.

For a read, the block opens each bit cell itself with a short low start pulse. It then turns the transceiver around and decodes the target's reply. In capture mode it times how long the target keeps the line low. In sample mode it reads the line level at one fixed point of the cell, which suits targets whose line glitches just after the start pulse. All timing is counted in clock ticks. The timing unit `T` is the number of ticks per target debug clock, given on `cfg_tick`.

Two state machines do the work. The byte machine has the states M_IDLE, M_ISSUE, M_BIT and M_FINISH. It moves M_IDLE→M_ISSUE on an accepted byte and M_ISSUE→M_BIT to start a bit. From M_BIT it goes to M_ISSUE when a bit ends and bits remain, or to M_FINISH after the last bit or a timeout, and M_FINISH→M_IDLE. The cell machine has the states B_IDLE, B_TX_LOW, B_TX_HIGH, B_RX_START, B_RX_WAIT and B_RX_TAIL. A write cell runs B_IDLE→B_TX_LOW→B_TX_HIGH→B_IDLE. A read cell runs B_IDLE→B_RX_START→B_RX_WAIT→B_RX_TAIL→B_IDLE, or leaves B_RX_WAIT straight to B_IDLE on a timeout.

Top module: `dline_master`

## Requirements
- R1: After reset, and whenever no byte is in progress, line_dir is 0, line_out is 1, and done and timeout are 0.
- R2: cmd_accept is high in a cycle where no byte is active and cmd_valid is high, and only once per byte. done is high for exactly one cycle: the cycle that follows the last bit cell, 16T cycles after that cell's falling edge. done is never high together with cmd_accept.
- R3: A write byte (cmd_write=1) produces eight low pulses on line_out, cmd_data[7] first. A 1 bit is low for 4T cycles and a 0 bit for 13T cycles, where T=cfg_tick (T≥1).
- R4: Each bit cell lasts 16T cycles and is followed by one high cycle, so the falling edges within a byte are 16T+1 cycles apart.
- R5: During a write byte, line_dir stays high without a break from the cycle after acceptance through the done cycle, which is 128T+9 consecutive cycles.
- R6: During a read byte (cmd_write=0), every cell starts with line_out low for 4T cycles while line_dir is high. line_dir is low for the rest of the cell, and line_out is never low while line_dir is low.
- R7: In capture mode (cfg_sample=0), line_in passes a two-stage synchronizer. A bit is 1 when the synchronized line is first seen high less than 10T cycles after the cell's falling edge, and 0 otherwise. A low after that first high is ignored.
- R8: In sample mode (cfg_sample=1), the bit is the synchronized level exactly 10T cycles after the falling edge, and highs before that point are ignored. The cell ends no earlier than 16T and not before the line is high after that point.
- R9: If the synchronized line is still low after more than cfg_limit cycles of reply wait, the byte aborts. done rises with timeout=1 at 4T+cfg_limit+1 cycles after that cell's falling edge, no further cells are started, and the next byte runs normally.
- R10: Read bits fill rx_data most significant bit first (the first bit received lands in rx_data[7]), and rx_data holds the byte while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tick | input | TICK_W | Ticks per target debug clock (T), at least 1 |
| cfg_sample | input | 1 | 1 = sample-mode decode, 0 = capture-mode decode |
| cfg_limit | input | TMO_W | Reply-wait cycle limit before timeout |
| cmd_valid | input | 1 | Byte request present |
| cmd_write | input | 1 | 1 = send cmd_data, 0 = receive a byte |
| cmd_data | input | BYTE_W | Byte to send |
| cmd_accept | output | 1 | Request taken this cycle |
| done | output | 1 | One-cycle byte completion strobe |
| timeout | output | 1 | Byte aborted on a stuck-low line, valid with done |
| rx_data | output | BYTE_W | Received byte, valid with done |
| line_in | input | 1 | Line level from the transceiver |
| line_out | output | 1 | Line drive value, 0 = pull low |
| line_dir | output | 1 | Transceiver direction, 1 = drive toward target |

## Verification
The hardest situation to reach from the ports is a reply whose line rises briefly right after the start pulse and then falls again before the decision point. In that case capture and sample decode must disagree. The bench contains a behavioural target that answers every start pulse with a per-bit waveform, including exactly this glitch shape and hold times placed two to four ticks on either side of the 10T threshold. A second target behaviour holds the line low indefinitely to force the timeout abort, and then releases it so that recovery can be checked on a following byte.

// File: rtl/dline_pkg.sv
package dline_pkg;
    // Cell timing in target-clock units
    localparam int unsigned ONE_LOW_TC  = 4;
    localparam int unsigned ZERO_LOW_TC = 13;
    localparam int unsigned START_TC    = 4;
    localparam int unsigned DECIDE_TC   = 10;
    localparam int unsigned CELL_TC     = 16;

    typedef enum logic [2:0] {
        B_IDLE,
        B_TX_LOW,
        B_TX_HIGH,
        B_RX_START,
        B_RX_WAIT,
        B_RX_TAIL
    } cell_state_e;

    typedef enum logic [1:0] {
        M_IDLE,
        M_ISSUE,
        M_BIT,
        M_FINISH
    } byte_state_e;
endpackage

// File: rtl/dline_timer.sv
module dline_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Saturating up-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (en && (q != TOP)) begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/dline_sync.sv
module dline_sync #(
    parameter int unsigned STAGES  = 2,
    parameter bit          RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= RST_VAL;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= RST_VAL;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dline_bitcell.sv
module dline_bitcell
    import dline_pkg::*;
#(
    parameter int unsigned TW = 8,
    parameter int unsigned CW = 16,
    parameter int unsigned LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          tx_mode,
    input  logic          tx_bit,
    input  logic          sample_mode,
    input  logic [TW-1:0] tick,
    input  logic [LW-1:0] limit,
    input  logic          line_s,
    output logic          bit_done,
    output logic          bit_tmo,
    output logic          rx_bit,
    output logic          drive_low,
    output logic          drive_en
);
    cell_state_e   st, st_n;
    logic [CW-1:0] cnt;
    logic [LW-1:0] wcnt;
    logic [CW-1:0] low_len, start_len, dec_len, cell_len;
    logic          take_cap, take_smp;
    logic          rx_q;

    // Spans in ticks
    assign low_len   = CW'(tick) * (tx_bit ? CW'(ONE_LOW_TC) : CW'(ZERO_LOW_TC));
    assign start_len = CW'(tick) * CW'(START_TC);
    assign dec_len   = CW'(tick) * CW'(DECIDE_TC);
    assign cell_len  = CW'(tick) * CW'(CELL_TC);

    // Ticks since the cell's falling edge
    dline_timer #(.W(CW)) u_cell_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st == B_IDLE),
        .en    (1'b1),
        .q     (cnt)
    );

    // Ticks spent waiting for the reply to end
    dline_timer #(.W(LW)) u_wait_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st != B_RX_WAIT),
        .en    (1'b1),
        .q     (wcnt)
    );

    always_comb begin
        st_n     = st;
        bit_done = 1'b0;
        bit_tmo  = 1'b0;
        take_cap = 1'b0;
        take_smp = 1'b0;
        unique case (st)
            B_IDLE: begin
                if (start) st_n = tx_mode ? B_TX_LOW : B_RX_START;
            end
            B_TX_LOW: begin
                if (cnt >= low_len - 1'b1) st_n = B_TX_HIGH;
            end
            B_TX_HIGH: begin
                if (cnt >= cell_len - 1'b1) begin
                    st_n     = B_IDLE;
                    bit_done = 1'b1;
                end
            end
            B_RX_START: begin
                if (cnt >= start_len - 1'b1) st_n = B_RX_WAIT;
            end
            B_RX_WAIT: begin
                if (sample_mode) begin
                    if (cnt == dec_len) take_smp = 1'b1;
                    if (line_s && (cnt > dec_len)) st_n = B_RX_TAIL;
                end else if (line_s) begin
                    take_cap = 1'b1;
                    st_n     = B_RX_TAIL;
                end
                if (!line_s && (wcnt >= limit)) begin
                    st_n     = B_IDLE;
                    bit_done = 1'b1;
                    bit_tmo  = 1'b1;
                end
            end
            B_RX_TAIL: begin
                if (cnt >= cell_len - 1'b1) begin
                    st_n     = B_IDLE;
                    bit_done = 1'b1;
                end
            end
            default: st_n = B_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= B_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rx_q <= 1'b0;
        else if (take_cap) rx_q <= (cnt < dec_len);
        else if (take_smp) rx_q <= line_s;
    end

    assign rx_bit = rx_q;

    always_comb begin
        drive_low = 1'b0;
        drive_en  = 1'b0;
        unique case (st)
            B_TX_LOW, B_RX_START: begin
                drive_low = 1'b1;
                drive_en  = 1'b1;
            end
            B_TX_HIGH: drive_en = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dline_master.sv
module dline_master
    import dline_pkg::*;
#(
    parameter int unsigned TICK_W      = 8,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned TMO_W       = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] cfg_tick,
    input  logic              cfg_sample,
    input  logic [TMO_W-1:0]  cfg_limit,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [BYTE_W-1:0] cmd_data,
    output logic              cmd_accept,
    output logic              done,
    output logic              timeout,
    output logic [BYTE_W-1:0] rx_data,
    input  logic              line_in,
    output logic              line_out,
    output logic              line_dir
);
    localparam int unsigned IDX_W = $clog2(BYTE_W);

    byte_state_e       mst, mst_n;
    logic [BYTE_W-1:0] shreg;
    logic [IDX_W-1:0]  left;
    logic              is_tx_q;
    logic              tmo_q;
    logic              busy;
    logic              line_s;
    logic              bit_start, bit_done, bit_tmo, rx_bit;
    logic              drv_low, drv_en;

    dline_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
    );

    dline_bitcell #(.TW(TICK_W), .CW(CNT_W), .LW(TMO_W)) u_cell (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (bit_start),
        .tx_mode     (is_tx_q),
        .tx_bit      (shreg[BYTE_W-1]),
        .sample_mode (cfg_sample),
        .tick        (cfg_tick),
        .limit       (cfg_limit),
        .line_s      (line_s),
        .bit_done    (bit_done),
        .bit_tmo     (bit_tmo),
        .rx_bit      (rx_bit),
        .drive_low   (drv_low),
        .drive_en    (drv_en)
    );

    always_comb begin
        mst_n = mst;
        unique case (mst)
            M_IDLE:   if (cmd_valid) mst_n = M_ISSUE;
            M_ISSUE:  mst_n = M_BIT;
            M_BIT: begin
                if (bit_done) mst_n = (bit_tmo || (left == '0)) ? M_FINISH : M_ISSUE;
            end
            M_FINISH: mst_n = M_IDLE;
            default:  mst_n = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mst <= M_IDLE;
        else        mst <= mst_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            left    <= '0;
            is_tx_q <= 1'b0;
            tmo_q   <= 1'b0;
        end else if ((mst == M_IDLE) && cmd_valid) begin
            shreg   <= cmd_data;
            left    <= IDX_W'(BYTE_W - 1);
            is_tx_q <= cmd_write;
            tmo_q   <= 1'b0;
        end else if ((mst == M_BIT) && bit_done) begin
            shreg   <= {shreg[BYTE_W-2:0], rx_bit};
            left    <= left - 1'b1;
            tmo_q   <= bit_tmo;
        end
    end

    assign busy = (mst != M_IDLE);

    always_comb begin
        cmd_accept = (mst == M_IDLE) && cmd_valid;
        bit_start  = (mst == M_ISSUE);
        done       = (mst == M_FINISH);
        timeout    = (mst == M_FINISH) && tmo_q;
        rx_data    = shreg;
        line_out   = !drv_low;
        line_dir   = drv_en || (busy && is_tx_q);
    end
endmodule

// File: rtl/dline_master_chk.sv
module dline_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic tx_mode,
    input logic cmd_accept,
    input logic done,
    input logic timeout,
    input logic line_out,
    input logic line_dir
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!line_dir && line_out && !timeout));

    // R6
    low_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_out |-> line_dir);

    // R5
    tx_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tx_mode) |-> line_dir);

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |=> (busy && !done));

    // R9
    tmo_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);
endmodule

bind dline_master dline_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .tx_mode    (is_tx_q),
    .cmd_accept (cmd_accept),
    .done       (done),
    .timeout    (timeout),
    .line_out   (line_out),
    .line_dir   (line_dir)
);

// File: tb/dline_master_bench.sv
module dline_master_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cfg_tick;
    logic       cfg_sample;
    logic [15:0] cfg_limit;
    logic       cmd_valid, cmd_write;
    logic [7:0] cmd_data;
    logic       cmd_accept, done, timeout;
    logic [7:0] rx_data;
    logic       line_in;
    logic       line_out, line_dir;

    always #5 clk = ~clk;  // 10 ns period

    dline_master u_dline_master (
        .clk(clk), .rst_n(rst_n), .cfg_tick(cfg_tick), .cfg_sample(cfg_sample),
        .cfg_limit(cfg_limit), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_data(cmd_data), .cmd_accept(cmd_accept), .done(done), .timeout(timeout),
        .rx_data(rx_data), .line_in(line_in), .line_out(line_out), .line_dir(line_dir)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Line monitor
    int   low_w [0:511];
    int   fall_t[0:511];
    int   dir_w [0:511];
    int   n_low = 0, n_fall = 0, n_dir = 0, n_acc = 0;
    int   cur_low = 0, cur_dir = 0;
    logic prev_out = 1'b1;
    always @(negedge clk) begin
        if (!line_out) begin
            if (prev_out) begin
                fall_t[n_fall] = cyc;
                n_fall++;
            end
            cur_low++;
        end else if (cur_low != 0) begin
            low_w[n_low] = cur_low;
            n_low++;
            cur_low = 0;
        end
        prev_out = line_out;
        if (line_dir) begin
            cur_dir++;
        end else if (cur_dir != 0) begin
            dir_w[n_dir] = cur_dir;
            n_dir++;
            cur_dir = 0;
        end
        if (cmd_accept) n_acc++;
    end

    // Behavioural target
    logic       resp_en = 1'b0;
    logic       resp_stuck = 1'b0;
    logic [7:0] resp_pat = 8'h00;
    logic [7:0] resp_glt = 8'h00;
    int         resp_h1 = 20;
    int         resp_h0 = 45;
    int         resp_base = 0;
    int         rx_falls = 0;
    initial begin
        line_in = 1'b1;
        forever begin
            @(negedge line_out);
            if (resp_stuck) begin
                line_in = 1'b0;
                wait (!resp_stuck);
                line_in = 1'b1;
            end else if (resp_en) begin
                automatic int b = 7 - (rx_falls - resp_base);
                rx_falls++;
                line_in = 1'b0;
                if (resp_glt[b]) begin
                    repeat (17) @(posedge clk);
                    #1 line_in = 1'b1;
                    repeat (4) @(posedge clk);
                    #1 line_in = 1'b0;
                    repeat (24) @(posedge clk);
                    #1 line_in = 1'b1;
                end else begin
                    repeat (resp_pat[b] ? resp_h1 : resp_h0) @(posedge clk);
                    #1 line_in = 1'b1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    int b_low, b_fall, b_dir, b_acc, t_done;
    logic [7:0] got_rx;
    logic       got_tmo;

    task automatic run_byte(input bit wr, input bit smp, input logic [7:0] d, input logic [7:0] g);
        cfg_sample = smp;
        resp_pat   = d;
        resp_glt   = g;
        resp_base  = rx_falls;
        resp_en    = !wr;
        b_low  = n_low;
        b_fall = n_fall;
        b_dir  = n_dir;
        b_acc  = n_acc;
        @(posedge clk);
        #1;
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_data  = d;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        t_done  = cyc;
        got_rx  = rx_data;
        got_tmo = timeout;
        @(negedge clk);
        chk(!done, "R2", done, 0);
        @(negedge clk);
        chk(n_acc - b_acc == 1, "R2", n_acc - b_acc, 1);
    endtask

    task automatic check_write(input logic [7:0] d, input int t);
        chk(n_low - b_low == 8, "R3", n_low - b_low, 8);
        for (int i = 0; i < 8; i++) begin
            automatic int exp = d[7-i] ? 4 * t : 13 * t;
            chk(low_w[b_low+i] == exp, "R3", low_w[b_low+i], exp);
        end
        for (int i = 1; i < 8; i++) begin
            chk(fall_t[b_fall+i] - fall_t[b_fall+i-1] == 16 * t + 1, "R4",
                fall_t[b_fall+i] - fall_t[b_fall+i-1], 16 * t + 1);
        end
        chk(n_dir - b_dir == 1, "R5", n_dir - b_dir, 1);
        chk(dir_w[b_dir] == 128 * t + 9, "R5", dir_w[b_dir], 128 * t + 9);
        chk(t_done - fall_t[b_fall+7] == 16 * t, "R2", t_done - fall_t[b_fall+7], 16 * t);
        chk(!got_tmo, "R9", got_tmo, 0);
    endtask

    task automatic check_read(input logic [7:0] exp, input int t, input string req);
        chk(n_low - b_low == 8, "R6", n_low - b_low, 8);
        chk(n_dir - b_dir == 8, "R6", n_dir - b_dir, 8);
        for (int i = 0; i < 8; i++) begin
            chk(low_w[b_low+i] == 4 * t, "R6", low_w[b_low+i], 4 * t);
            chk(dir_w[b_dir+i] == 4 * t, "R6", dir_w[b_dir+i], 4 * t);
        end
        chk(got_rx == exp, req, got_rx, exp);
        chk(!got_tmo, "R9", got_tmo, 0);
        chk(t_done - fall_t[b_fall+7] == 16 * t, "R2", t_done - fall_t[b_fall+7], 16 * t);
    endtask

    // {write, sample, data/pattern, glitch mask, expected rx}
    localparam logic [25:0] VEC [0:7] = '{
        {1'b1, 1'b0, 8'hA5, 8'h00, 8'h00},
        {1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
        {1'b1, 1'b0, 8'hFF, 8'h00, 8'h00},
        {1'b0, 1'b0, 8'h3C, 8'h00, 8'h3C},
        {1'b0, 1'b1, 8'hC3, 8'h00, 8'hC3},
        {1'b0, 1'b0, 8'h00, 8'h81, 8'h81},
        {1'b0, 1'b1, 8'h00, 8'h81, 8'h00},
        {1'b0, 1'b1, 8'h5A, 8'h00, 8'h5A}
    };

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        summary();
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        cmd_valid  = 1'b0;
        cmd_write  = 1'b0;
        cmd_data   = 8'h00;
        cfg_tick   = 8'd4;
        cfg_sample = 1'b0;
        cfg_limit  = 16'd2000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(line_dir == 1'b0, "R1", line_dir, 0);
        chk(line_out == 1'b1, "R1", line_out, 1);
        chk(done == 1'b0, "R1", done, 0);
        chk(timeout == 1'b0, "R1", timeout, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(line_dir == 1'b0 && line_out == 1'b1, "R1", {line_dir, line_out}, 1);

        for (int v = 0; v < 8; v++) begin
            automatic logic [25:0] e = VEC[v];
            run_byte(e[25], e[24], e[23:16], e[15:8]);
            if (e[25]) check_write(e[23:16], 4);
            else       check_read(e[7:0], 4, e[24] ? "R8 R10" : "R7 R10");
        end

        // Threshold boundary: holds of 34 and 40 ticks around 10T=40
        resp_h1 = 34;
        resp_h0 = 40;
        run_byte(1'b0, 1'b0, 8'hA5, 8'h00);
        check_read(8'hA5, 4, "R7");
        run_byte(1'b0, 1'b1, 8'hA5, 8'h00);
        check_read(8'hA5, 4, "R8");
        resp_h1 = 20;
        resp_h0 = 45;

        // Different tick scale on a write
        cfg_tick = 8'd2;
        run_byte(1'b1, 1'b0, 8'h96, 8'h00);
        check_write(8'h96, 2);
        cfg_tick = 8'd4;

        // R9 stuck-low line then recovery
        cfg_limit  = 16'd100;
        resp_stuck = 1'b1;
        run_byte(1'b0, 1'b0, 8'hFF, 8'h00);
        chk(got_tmo == 1'b1, "R9", got_tmo, 1);
        chk(n_fall - b_fall == 1, "R9", n_fall - b_fall, 1);
        chk(t_done - fall_t[b_fall] == 4 * 4 + 100 + 1, "R9", t_done - fall_t[b_fall], 117);
        chk(line_dir == 1'b0 && line_out == 1'b1, "R1", {line_dir, line_out}, 1);
        resp_stuck = 1'b0;
        repeat (5) @(negedge clk);
        run_byte(1'b0, 1'b0, 8'h69, 8'h00);
        check_read(8'h69, 4, "R9");

        summary();
        $finish;
    end
endmodule